// File: doc/BRIEF.md
# Next Fetch Address Predictor with Target Buffer

This block chooses the address the fetch stage reads in the next cycle. It takes the current program counter and looks it up in a small tagged, direct-mapped target buffer. Each entry holds the target that a branch at that address went to the last time it was taken. A valid entry whose tag matches marks the fetched instruction as a branch. A static direction mode then picks one of two addresses: the stored target, or the sequential address (PC plus the fixed instruction size). A lookup that misses always gives the sequential address.

When a branch resolves later in the pipeline, its outcome comes back on a resolve port. The port carries the branch PC, the taken flag, the actual target and the address the predictor gave for that branch. A taken outcome writes the branch's tag and target into the entry at its index. This allocates a new entry or refreshes an existing one. A not-taken outcome leaves the buffer as it is. One cycle after the resolve, the block raises a flag if the real next address differs from the predicted address that came in with the resolve request.

Top module: `nextpc_btb`

## Requirements
- R1: Reset clears every valid bit, so after reset every lookup misses, `next_pc` equals `fetch_pc + 4` and `mispredict` is low.
- R2: A lookup hits only when the entry at index `fetch_pc[5:2]` is valid and its stored tag equals `fetch_pc[31:6]`. Another branch whose PC maps to the same index but has a different tag gives a miss.
- R3: On a miss, `next_pc` is `fetch_pc + 4` and `pred_taken` is 0, whatever the mode.
- R4: In mode 2'b01 (always taken), a hit gives `pred_taken` = 1 and `next_pc` = the stored target.
- R5: In mode 2'b10 (backward taken, forward not taken), a hit whose stored target is strictly below `fetch_pc` (unsigned) gives the target with `pred_taken` = 1. Any other hit, including a target equal to the PC, gives `fetch_pc + 4` with `pred_taken` = 0.
- R6: In modes 2'b00 and 2'b11 (never taken), `next_pc` is always `fetch_pc + 4` and `pred_taken` is 0. `hit` is still reported.
- R7: A resolve with `rs_valid` = 1 and `rs_taken` = 1 writes the tag and target of `rs_pc` into its entry, either allocating it or replacing its target. From the next cycle on, a lookup of that PC hits and returns `rs_target`.
- R8: A resolve with `rs_taken` = 0 leaves the buffer unchanged. A not-taken branch that missed is not allocated, and an existing entry keeps its target.
- R9: `mispredict` is high in the cycle after a resolve edge exactly when the real next address differs from `rs_pred_next`. The real next address is `rs_target` if taken, otherwise `rs_pc + 4`. `mispredict` is low after any cycle with no resolve.
- R10: A lookup in the same cycle as a write to its entry sees the contents the entry had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Static direction mode: 00/11 never, 01 always, 10 backward only |
| fetch_pc | input | 32 | Program counter being fetched |
| next_pc | output | 32 | Predicted fetch address for the next cycle |
| hit | output | 1 | Buffer hit: fetched instruction is a known branch |
| pred_taken | output | 1 | Predicted direction applied to this fetch |
| rs_valid | input | 1 | Resolve request present |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_taken | input | 1 | Resolved direction |
| rs_target | input | 32 | Resolved target address |
| rs_pred_next | input | 32 | Next address that was predicted for this branch |
| mispredict | output | 1 | One-cycle flag: prediction for the resolved branch was wrong |

## Verification
The lookup outputs `next_pc`, `hit` and `pred_taken` are combinational and are due in the same cycle as `fetch_pc`. The bench samples them 1 ns after driving inputs on the falling edge. A resolve takes effect at the next rising edge: the buffer contents and `mispredict` change there. The reference model therefore updates its buffer and its expected flag at that edge, and compares them during the following cycle. This timing also covers the same-cycle lookup case in R10, since a lookup that coincides with a write must still see the old entry.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  // Static direction modes selected on the mode input
  typedef enum logic [1:0] {
    DIR_NEVER     = 2'b00,
    DIR_ALWAYS    = 2'b01,
    DIR_BACKWARD  = 2'b10,
    DIR_NEVER_ALT = 2'b11
  } dir_mode_e;
endpackage

// File: rtl/nextpc_table.sv
module nextpc_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_tgt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [ENTRIES-1:0] ent_match;

  // valid bits: cleared on reset, set on a write
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // payload storage needs no reset: guarded by valid
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  // per-entry match lines, at most one can be set
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign ent_match[g] = valid_q[g] && (lk_idx == IDX_W'(g)) && (tag_q[g] == lk_tag);
  end

  assign lk_hit = |ent_match;
  assign lk_tgt = tgt_q[lk_idx];
endmodule

// File: rtl/nextpc_policy.sv
module nextpc_policy
  import nextpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic              hit,
  input  logic [ADDR_W-1:0] tgt,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(INST_BYTES);
  endfunction

  function automatic logic goes_back(input logic [ADDR_W-1:0] t, input logic [ADDR_W-1:0] a);
    return t < a;
  endfunction

  logic dir_taken;

  always_comb begin
    unique case (dir_mode_e'(mode))
      DIR_ALWAYS:   dir_taken = 1'b1;
      DIR_BACKWARD: dir_taken = goes_back(tgt, pc);
      default:      dir_taken = 1'b0;
    endcase
  end

  assign taken   = hit && dir_taken;
  assign next_pc = taken ? tgt : seq_addr(pc);
endmodule

// File: rtl/nextpc_resolve.sv
module nextpc_resolve #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic [ADDR_W-1:0] rs_pred_next,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_tgt,
  output logic              mispredict
);
  function automatic logic [ADDR_W-1:0] real_next(input logic tk,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] t);
    return tk ? t : a + ADDR_W'(INST_BYTES);
  endfunction

  logic wrong_guess;
  logic misp_q;

  assign wrong_guess = rs_valid && (real_next(rs_taken, rs_pc, rs_target) != rs_pred_next);
  assign wr_en       = rs_valid && rs_taken && !rst;
  assign wr_tgt      = rs_target;

  always_ff @(posedge clk) begin
    if (rst) misp_q <= 1'b0;
    else     misp_q <= wrong_guess;
  end

  assign mispredict = misp_q;
endmodule

// File: rtl/nextpc_btb.sv
module nextpc_btb #(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int INST_BYTES = 4,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int OFS_W     = $clog2(INST_BYTES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              hit,
  output logic              pred_taken,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic [ADDR_W-1:0] rs_pred_next,
  output logic              mispredict
);
  // named internal events for the checker
  logic              lk_hit;
  logic [ADDR_W-1:0] lk_tgt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_tgt;

  nextpc_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (fetch_pc[OFS_W +: IDX_W]),
    .lk_tag (fetch_pc[ADDR_W-1 -: TAG_W]),
    .lk_hit (lk_hit),
    .lk_tgt (lk_tgt),
    .wr_en  (wr_en),
    .wr_idx (rs_pc[OFS_W +: IDX_W]),
    .wr_tag (rs_pc[ADDR_W-1 -: TAG_W]),
    .wr_tgt (wr_tgt)
  );

  nextpc_policy #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_policy (
    .mode    (mode),
    .pc      (fetch_pc),
    .hit     (lk_hit),
    .tgt     (lk_tgt),
    .taken   (pred_taken),
    .next_pc (next_pc)
  );

  nextpc_resolve #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_resolve (
    .clk          (clk),
    .rst          (rst),
    .rs_valid     (rs_valid),
    .rs_pc        (rs_pc),
    .rs_taken     (rs_taken),
    .rs_target    (rs_target),
    .rs_pred_next (rs_pred_next),
    .wr_en        (wr_en),
    .wr_tgt       (wr_tgt),
    .mispredict   (mispredict)
  );

  assign hit = lk_hit;
endmodule

// File: rtl/nextpc_btb_chk.sv
module nextpc_btb_chk #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] next_pc,
  input logic              hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] lk_tgt,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_pc,
  input logic              rs_taken,
  input logic [ADDR_W-1:0] rs_target,
  input logic [ADDR_W-1:0] rs_pred_next,
  input logic              mispredict
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  p_miss_seq_r3: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (next_pc == fetch_pc + STEP) && !pred_taken);

  p_always_tgt_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == 2'b01) |-> (next_pc == lk_tgt) && pred_taken);

  p_back_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == 2'b10) |-> (pred_taken == (lk_tgt < fetch_pc)));

  p_never_seq_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |-> (next_pc == fetch_pc + STEP) && !pred_taken);

  p_alloc_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rs_valid && rs_taken) && fetch_pc == $past(rs_pc))
      |-> hit && (lk_tgt == $past(rs_target)));

  p_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rs_valid && !rs_taken) && $stable(fetch_pc))
      |-> $stable(hit) && $stable(lk_tgt));

  p_misp_src_r9: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(rs_valid));

  p_misp_ok_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rs_valid && !rs_taken) && $past(rs_pred_next) == $past(rs_pc) + STEP)
      |-> !mispredict);
endmodule

bind nextpc_btb nextpc_btb_chk #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode         (mode),
  .fetch_pc     (fetch_pc),
  .next_pc      (next_pc),
  .hit          (hit),
  .pred_taken   (pred_taken),
  .lk_tgt       (lk_tgt),
  .rs_valid     (rs_valid),
  .rs_pc        (rs_pc),
  .rs_taken     (rs_taken),
  .rs_target    (rs_target),
  .rs_pred_next (rs_pred_next),
  .mispredict   (mispredict)
);

// File: tb/nextpc_btb_bench.sv
module nextpc_btb_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic [31:0] fetch_pc;
  logic [31:0] next_pc;
  logic        hit;
  logic        pred_taken;
  logic        rs_valid;
  logic [31:0] rs_pc;
  logic        rs_taken;
  logic [31:0] rs_target;
  logic [31:0] rs_pred_next;
  logic        mispredict;

  int n_checks = 0;
  int n_errors = 0;

  // behavioural model: index -> last taken branch PC and its target
  logic [31:0] m_bpc [int];
  logic [31:0] m_tgt [int];
  logic        exp_misp;

  always #2.5 clk = ~clk;

  nextpc_btb u_nextpc_btb (
    .clk(clk), .rst(rst), .mode(mode), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .hit(hit), .pred_taken(pred_taken), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_next(rs_pred_next),
    .mispredict(mispredict)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive, compare lookup and flag, then advance the model at the edge
  task automatic cyc(input logic [1:0] md, input logic [31:0] fpc,
                     input logic v, input logic [31:0] rpc, input logic tk,
                     input logic [31:0] rtg, input logic [31:0] rpred, input string req);
    int ix;
    logic e_hit, e_tk;
    logic [31:0] e_next, real_nx;
    @(negedge clk);
    mode = md; fetch_pc = fpc; rs_valid = v; rs_pc = rpc;
    rs_taken = tk; rs_target = rtg; rs_pred_next = rpred;
    #1;
    ix = int'(fpc[5:2]);
    e_hit = m_bpc.exists(ix) && (m_bpc[ix][31:6] == fpc[31:6]);
    case (md)
      2'b01:   e_tk = e_hit;
      2'b10:   e_tk = e_hit && (m_tgt[ix] < fpc);
      default: e_tk = 1'b0;
    endcase
    e_next = e_tk ? m_tgt[ix] : fpc + 32'd4;
    chk(hit == e_hit, req, "hit", {31'd0, hit}, {31'd0, e_hit});
    chk(pred_taken == e_tk, req, "pred_taken", {31'd0, pred_taken}, {31'd0, e_tk});
    chk(next_pc == e_next, req, "next_pc", next_pc, e_next);
    chk(mispredict == exp_misp, req, "mispredict", {31'd0, mispredict}, {31'd0, exp_misp});
    @(posedge clk);
    real_nx  = tk ? rtg : rpc + 32'd4;
    exp_misp = v && (real_nx != rpred);
    if (v && tk) begin
      m_bpc[int'(rpc[5:2])] = rpc;
      m_tgt[int'(rpc[5:2])] = rtg;
    end
  endtask

  initial begin
    #1000000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'b01; fetch_pc = 32'h100; rs_valid = 1'b0; rs_pc = '0;
    rs_taken = 1'b0; rs_target = '0; rs_pred_next = '0;
    exp_misp = 1'b0;
    m_bpc.delete(); m_tgt.delete();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: empty after reset
    cyc(2'b01, 32'h0000_0100, 0, 0, 0, 0, 0, "R1");
    cyc(2'b01, 32'h0000_1000, 0, 0, 0, 0, 0, "R1");
    // R7/R9/R10: allocate with a wrong guess; same-cycle lookup still misses
    cyc(2'b01, 32'h0000_1000, 1, 32'h1000, 1, 32'h0800, 32'h1004, "R10");
    // R4 R7: now hits; R9: flag from previous resolve
    cyc(2'b01, 32'h0000_1000, 0, 0, 0, 0, 0, "R4 R7 R9");
    cyc(2'b00, 32'h0000_1000, 0, 0, 0, 0, 0, "R6");
    cyc(2'b11, 32'h0000_1000, 0, 0, 0, 0, 0, "R6");
    cyc(2'b10, 32'h0000_1000, 0, 0, 0, 0, 0, "R5");
    // R2: aliasing branch at same index replaces the entry (correct guess)
    cyc(2'b10, 32'h0000_1000, 1, 32'h2000, 1, 32'h3000, 32'h3000, "R7");
    cyc(2'b01, 32'h0000_1000, 0, 0, 0, 0, 0, "R2 R9");
    cyc(2'b10, 32'h0000_2000, 0, 0, 0, 0, 0, "R5");
    // R8: not-taken resolve on existing entry and on a missing one
    cyc(2'b01, 32'h0000_2000, 1, 32'h2000, 0, 32'h9990, 32'h2004, "R8");
    cyc(2'b01, 32'h0000_2000, 1, 32'h2404, 0, 32'h5550, 32'h5550, "R8 R9");
    cyc(2'b01, 32'h0000_2404, 0, 0, 0, 0, 0, "R8 R9");
    // R7: refresh target, backward now
    cyc(2'b10, 32'h0000_2000, 1, 32'h2000, 1, 32'h1F00, 32'h3000, "R7");
    cyc(2'b10, 32'h0000_2000, 0, 0, 0, 0, 0, "R5 R7 R9");
    // R5 boundary: target equal to PC is not backward
    cyc(2'b10, 32'h0000_2000, 1, 32'h2000, 1, 32'h2000, 32'h2000, "R5");
    cyc(2'b10, 32'h0000_2000, 0, 0, 0, 0, 0, "R5");
    cyc(2'b01, 32'h0000_2000, 0, 0, 0, 0, 0, "R4");

    // mixed traffic with heavy index aliasing
    for (int i = 0; i < 600; i++) begin
      logic [31:0] fpc, rpc, rtg, rpr;
      logic v, tk;
      fpc = 32'h4000 + ($urandom_range(0, 3) << 6) + ($urandom_range(0, 15) << 2);
      rpc = 32'h4000 + ($urandom_range(0, 3) << 6) + ($urandom_range(0, 15) << 2);
      rtg = 32'h4000 + ($urandom_range(0, 255) << 2);
      v   = ($urandom_range(0, 2) != 0);
      tk  = $urandom_range(0, 1) == 1;
      rpr = ($urandom_range(0, 1) == 1) ? (tk ? rtg : rpc + 32'd4) : rtg + 32'd8;
      cyc(2'($urandom_range(0, 3)), fpc, v, rpc, tk, rtg, rpr, "R2 R3 R4 R5 R6 R7 R8 R9");
    end

    // R1: reset again empties the buffer
    @(negedge clk); rst = 1'b1; rs_valid = 1'b0;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    exp_misp = 1'b0; m_bpc.delete(); m_tgt.delete();
    cyc(2'b01, 32'h0000_2000, 0, 0, 0, 0, 0, "R1 R3");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule